// File: doc/BRIEF.md
# PMIC Bus Command Port

This block is a small register-mapped front end through which software issues one read or one write at a time toward a serial power-management bus master. Software first polls a status word until the handshake machine reports idle. For a write it loads the payload and then the command word. For a read it writes the command word, polls until the machine reports that data is waiting, reads the captured data and writes a valid-clear register to release the port.

The machine has four states, and each one shows in the status word. In request it drives a request with the decoded command fields to the bus master until the master accepts it. In busy it waits for the master's done pulse. In hold it keeps read data latched. A write finishes on the done pulse without any acknowledgement from software. Up to four data bytes travel in the low byte lanes of the 32-bit data words. Lanes above the byte count are zeroed.

Top module: `pmic_cmd_port`

## Requirements
- R1: After synchronous active-low reset the status state field reads idle (0), the read-data register reads 0 and `mst_req` is low.
- R2: The status word at offset 0x00 carries the state code in bits [3:1] (idle 0, request 2, busy 4, hold 6) and the `init_done` input in bit 15. All other bits read 0.
- R3: A write to the command register (0x04) in idle moves the state to request. It drives `mst_req` with type = bits [31:30], write flag = bit 29 (1 = write), slave ID = bits [28:24], byte count minus one = bits [23:16] and address = bits [15:0] of the written word.
- R4: `mst_req` stays high until a cycle with `mst_ack` high. The state is busy in the cycle after that, with `mst_req` low.
- R5: For a write command, a `mst_done` pulse in busy returns the state to idle in the next cycle.
- R6: For a read command, a `mst_done` pulse in busy moves the state to hold. It captures `mst_rdata` into the read-data register (0x0C), keeping the lowest (bytecount & 3) + 1 byte lanes and zeroing the rest.
- R7: In hold, the read data and the state stay unchanged until a write to 0x10 with bit 0 set. After that write the state is idle.
- R8: A command-register write while the state is not idle is ignored: the command readback at 0x04 and the state are unchanged.
- R9: A valid-clear write outside hold, or one with bit 0 clear, leaves the state unchanged.
- R10: `mst_wdata` is the write-data register with only the lowest (bytecount & 3) + 1 byte lanes kept. Write-data writes outside idle are ignored.
- R11: Offsets 0x04 and 0x08 read back the last accepted command and write data. Offsets 0x10 and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| init_done | input | 1 | Interface initialisation complete |
| mst_req | output | 1 | Command request to bus master |
| mst_type | output | 2 | Command type code |
| mst_write | output | 1 | 1 = write, 0 = read |
| mst_sid | output | 5 | Slave ID |
| mst_bc | output | 8 | Byte count minus one |
| mst_addr | output | 16 | Register address on the slave |
| mst_wdata | output | 32 | Lane-masked write payload |
| mst_ack | input | 1 | Master accepted the request |
| mst_done | input | 1 | Master finished the transaction |
| mst_rdata | input | 32 | Read data from master, valid with done |

## Verification
Several properties are checked on every cycle: the request is held until it is accepted, read data and the hold state stay put until a proper clear, command writes outside idle never alter the stored command, a write's done pulse returns the machine to idle, and clears in idle do nothing. Other behaviour shows only in the bench's scenarios. These are the exact status encodings, the field decode of the command word, the lane masking for each byte count (including counts above three), the write-data lock while busy and the readback of each offset. The bench sweeps both directions over all four type codes and several byte counts to cover them.

// File: rtl/pmic_cmd_port.sv
module pmic_cmd_port #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              init_done,
  output logic              mst_req,
  output logic [1:0]        mst_type,
  output logic              mst_write,
  output logic [4:0]        mst_sid,
  output logic [7:0]        mst_bc,
  output logic [15:0]       mst_addr,
  output logic [31:0]       mst_wdata,
  input  logic              mst_ack,
  input  logic              mst_done,
  input  logic [31:0]       mst_rdata
);

  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_WD   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_RD   = ADDR_W'(8'h0C);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd2,
    ST_BUSY = 3'd4,
    ST_HOLD = 3'd6
  } st_t;

  st_t         st_q;
  logic [31:0] cmd_q, wd_q, rd_q, lane_mask;

  wire is_idle  = (st_q == ST_IDLE);
  wire take_cmd = reg_wr && reg_addr == OFS_CMD && is_idle;
  wire take_wd  = reg_wr && reg_addr == OFS_WD && is_idle;
  wire do_clr   = reg_wr && reg_addr == ADDR_W'(8'h10) && reg_wdata[0] && st_q == ST_HOLD;

  always_comb
    for (int i = 0; i < 4; i++)
      lane_mask[8*i +: 8] = (2'(i) <= cmd_q[17:16]) ? 8'hFF : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (take_wd) wd_q <= reg_wdata;
      case (st_q)
        ST_IDLE: if (take_cmd) begin
          cmd_q <= reg_wdata;
          st_q  <= ST_REQ;
        end
        ST_REQ:  if (mst_ack) st_q <= ST_BUSY;
        ST_BUSY: if (mst_done) begin
          if (cmd_q[29]) st_q <= ST_IDLE;
          else begin
            rd_q <= mst_rdata & lane_mask;
            st_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (do_clr) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mst_req   = (st_q == ST_REQ);
  assign mst_type  = cmd_q[31:30];
  assign mst_write = cmd_q[29];
  assign mst_sid   = cmd_q[28:24];
  assign mst_bc    = cmd_q[23:16];
  assign mst_addr  = cmd_q[15:0];
  assign mst_wdata = wd_q & lane_mask;

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {16'h0, init_done, 11'h0, st_q, 1'b0};
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_WD:   reg_rdata = wd_q;
      OFS_RD:   reg_rdata = rd_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

module pmic_cmd_port_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        st_q,
  input logic [31:0]       cmd_q,
  input logic [31:0]       rd_q,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mst_req,
  input logic              mst_ack,
  input logic              mst_done
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(8'h10);

  wire clr_set = reg_wr && reg_addr == A_CLR && reg_wdata[0];

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_ack) |=> mst_req);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 3'd6 && !clr_set) |=> (st_q == 3'd6 && $stable(rd_q)));

  // R8
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 3'd0 && reg_wr && reg_addr == A_CMD) |=> $stable(cmd_q));

  // R5
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 3'd4 && mst_done && cmd_q[29]) |=> st_q == 3'd0);

  // R9
  idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 3'd0 && reg_wr && reg_addr == A_CLR) |=> st_q == 3'd0);
endmodule

bind pmic_cmd_port pmic_cmd_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_q(st_q), .cmd_q(cmd_q), .rd_q(rd_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mst_req(mst_req), .mst_ack(mst_ack), .mst_done(mst_done)
);

// File: tb/test_pmic_cmd_port.sv
module test_pmic_cmd_port;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic init_done = 0;
  logic mst_req, mst_write, mst_ack = 0, mst_done = 0;
  logic [1:0] mst_type;
  logic [4:0] mst_sid;
  logic [7:0] mst_bc;
  logic [15:0] mst_addr;
  logic [31:0] mst_wdata, mst_rdata = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pmic_cmd_port i_pmic_cmd_port (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; #1;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] lanes(logic [7:0] bc);
    int n = int'(bc % 4) + 1;
    return (n == 4) ? 32'hFFFF_FFFF : (32'h1 << (8 * n)) - 1;
  endfunction

  task automatic run(bit dir, logic [1:0] ty, logic [4:0] sid, logic [7:0] bc,
                     logic [15:0] ad, logic [31:0] wd, logic [31:0] rp, int dly);
    logic [31:0] cmd, v, m;
    cmd = {ty, dir, sid, bc, ad};
    m = lanes(bc);
    wr(5'h08, wd);
    wr(5'h04, cmd);
    rd(5'h00, v); check("R3 status request", v, 32'h8004);
    check("R3 req", {31'h0, mst_req}, 1);
    check("R3 fields", {mst_type, mst_write, mst_sid, mst_bc, mst_addr}, cmd);
    check("R10 wdata lanes", mst_wdata, wd & m);
    wr(5'h08, ~wd);
    check("R10 wdata locked", mst_wdata, wd & m);
    wr(5'h04, ~cmd);
    rd(5'h04, v); check("R8 cmd ignored in request", v, cmd);
    for (int i = 0; i < dly; i++) @(negedge clk);
    #1;
    check("R4 req held", {31'h0, mst_req}, 1);
    mst_ack = 1; @(negedge clk); mst_ack = 0; #1;
    rd(5'h00, v); check("R4 status busy", v, 32'h8008);
    check("R4 req dropped", {31'h0, mst_req}, 0);
    wr(5'h10, 1);
    rd(5'h00, v); check("R9 clear in busy", v, 32'h8008);
    wr(5'h04, ~cmd);
    rd(5'h04, v); check("R8 cmd ignored in busy", v, cmd);
    mst_done = 1; mst_rdata = rp; @(negedge clk); mst_done = 0; mst_rdata = ~rp; #1;
    if (dir) begin
      rd(5'h00, v); check("R5 write done idle", v, 32'h8000);
    end else begin
      rd(5'h00, v); check("R6 status hold", v, 32'h800C);
      rd(5'h0C, v); check("R6 rdata lanes", v, rp & m);
      repeat (3) @(negedge clk);
      wr(5'h10, 0);
      rd(5'h00, v); check("R9 clear bit0 low", v, 32'h800C);
      wr(5'h04, ~cmd);
      rd(5'h04, v); check("R8 cmd ignored in hold", v, cmd);
      rd(5'h0C, v); check("R7 rdata stable", v, rp & m);
      wr(5'h10, 1);
      rd(5'h00, v); check("R7 cleared to idle", v, 32'h8000);
    end
    rd(5'h08, v); check("R11 wdata readback", v, wd);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    rd(5'h00, v); check("R1 status idle", v, 0);
    rd(5'h0C, v); check("R1 rdata zero", v, 0);
    check("R1 req low", {31'h0, mst_req}, 0);
    init_done = 1;
    rd(5'h00, v); check("R2 init bit", v, 32'h8000);
    rd(5'h14, v); check("R11 unmapped", v, 0);
    rd(5'h10, v); check("R11 clear reads 0", v, 0);
    wr(5'h10, 1);
    rd(5'h00, v); check("R9 clear in idle", v, 32'h8000);
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 6; b++) begin
        logic [7:0] bc;
        bc = (b < 4) ? 8'(b) : ((b == 4) ? 8'h06 : 8'hFF);
        run(d[0], 2'(b), 5'(b * 5 + d), bc, 16'h1234 ^ 16'(b << 8),
            32'hA1B2_C3D4 + 32'(b * 32'h0101_0101), 32'h5E6F_7A8B ^ 32'(b << 4), b % 3);
      end
    init_done = 0;
    rd(5'h00, v); check("R2 init low", v, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule